// File: doc/BRIEF.md
# Double-Buffered Multichannel LED Dimmer

This block dims a bank of LEDs, one pulse-width-modulated output per channel, all timed by one shared free-running 8-bit counter. A host reaches it through a byte-wide write port with an address, a data byte and a one-cycle write strobe. The bus target that produces those writes sits outside the block.

Brightness values are written into a staging register per channel. The outputs do not follow them until a write to the commit address. That write copies every staged value into the active set at once. Each channel's comparator then takes its new active value only when the shared counter rolls over, so no PWM period is cut short. Software can turn any channel on or off, stop all outputs with a shutdown bit or a global mask bit, and put the whole register file back to its defaults with a single write to the clear address.

Top module: `led_pwm_ctrl`

## Requirements
- R1: The staged brightness of channel n (1-based, n = 1..36) is written at address 0x01 + n - 1 with an 8-bit value. A staged value alone does not change any output.
- R2: A write of any data value to address 0x25 copies every staged brightness into the active brightness set in the same clock edge. Several brightness writes followed by one commit give the same outputs as a commit after each write.
- R3: Bit 0 of the register at address 0x26 + n - 1 enables channel n. While that bit is 0 the channel's output stays low.
- R4: Bit 0 of the register at address 0x00 selects the run state: 0 holds every output low and 1 allows normal output. Its default is 0.
- R5: When bit 0 of the register at address 0x4a is 1, every output is held low. The stored brightness and enable values are unchanged, and writing 0x00 brings the previous outputs back.
- R6: A write of any value to address 0x4f returns staged brightness, active brightness, enables, the run bit and the global mask to 0 on that edge. The counter keeps running.
- R7: The counter reads 0 in the first cycle after reset, rises by one each clock and wraps from 255 to 0. A channel's output is high while the counter is below its compare value. A compare value of 0 never gives a high output, and 255 gives 255 high cycles in every 256.
- R8: A channel's compare value takes the active brightness only on the edge where the counter wraps from 255 to 0. A commit in the middle of a period leaves that period unchanged.
- R9: Writes to addresses that none of the above use change no register and no output.
- R10: After reset, all outputs are low and every register holds its default value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| pwm_o | output | 36 | PWM output per channel, bit n-1 for channel n |

## Verification
A register write is captured on the clock edge that ends its strobe cycle. The run bit, the global mask and the enables act on the outputs in the very next cycle, so the soft-clear check samples directly after that edge. A committed brightness shows up only after the following counter wrap. The bench therefore keeps its own phase count of the counter, which starts at 0 after reset and rises by one per clock. After each commit it waits until a wrap has passed, then counts the high cycles of every output over exactly 256 cycles. The test for mid-period commits samples at chosen counter phases before and after the wrap.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    localparam int ADDR_W = 8;
    localparam int DUTY_W = 8;

    // Address map; channel slots are consecutive from their base
    localparam logic [ADDR_W-1:0] A_RUN    = 8'h00;
    localparam logic [ADDR_W-1:0] A_DUTY0  = 8'h01;
    localparam logic [ADDR_W-1:0] A_COMMIT = 8'h25;
    localparam logic [ADDR_W-1:0] A_EN0    = 8'h26;
    localparam logic [ADDR_W-1:0] A_GMASK  = 8'h4a;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h4f;

    typedef logic [DUTY_W-1:0] duty_t;

    // Global control state
    typedef struct packed {
        logic              run;
        logic [DUTY_W-1:0] gmask;
    } glob_t;

    // Decoded single-register hits
    typedef struct packed {
        logic commit;
        logic clear;
        logic run;
        logic gmask;
    } hit_t;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                   input int idx);
        return base + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
    import led_pwm_pkg::*;
#(
    parameter int NCH = 36
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DUTY_W-1:0]            wr_data,
    output logic [NCH-1:0][DUTY_W-1:0]   active_o,
    output logic [NCH-1:0]               en_o,
    output logic                         live_o,
    output logic                         clear_o
);

    logic [NCH-1:0][DUTY_W-1:0] staged;
    logic [NCH-1:0][DUTY_W-1:0] active;
    logic [NCH-1:0]             en;
    glob_t                      glob;
    hit_t                       hit;
    logic [NCH-1:0]             duty_hit;
    logic [NCH-1:0]             en_hit;
    logic                       mapped;

    always_comb begin
        hit.commit = wr_en && (wr_addr == A_COMMIT);
        hit.clear  = wr_en && (wr_addr == A_CLEAR);
        hit.run    = wr_en && (wr_addr == A_RUN);
        hit.gmask  = wr_en && (wr_addr == A_GMASK);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign duty_hit[i] = wr_en && (wr_addr == slot_addr(A_DUTY0, i));
        assign en_hit[i]   = wr_en && (wr_addr == slot_addr(A_EN0, i));
    end

    assign mapped = (|duty_hit) || (|en_hit) || (|hit);

    always_ff @(posedge clk) begin
        if (rst || hit.clear) begin
            staged <= '0;
            active <= '0;
            en     <= '0;
            glob   <= '0;
        end else begin
            if (hit.run)    glob.run   <= wr_data[0];
            if (hit.gmask)  glob.gmask <= wr_data;
            if (hit.commit) active     <= staged;
            for (int i = 0; i < NCH; i++) begin
                if (duty_hit[i]) staged[i] <= wr_data;
                if (en_hit[i])   en[i]     <= wr_data[0];
            end
        end
    end

    assign active_o = active;
    assign en_o     = en;
    assign live_o   = glob.run && !glob.gmask[0];
    assign clear_o  = hit.clear;

    // R2: commit copies the staged set in one step
    assert_commit_copy_R2: assert property (@(posedge clk) disable iff (rst)
        (hit.commit) |=> (active == $past(staged)));

    // R6: clear returns control state to defaults
    assert_clear_defaults_R6: assert property (@(posedge clk) disable iff (rst)
        (hit.clear) |=> (en == '0 && !live_o && active == '0));

    // R9: unmapped writes touch nothing
    assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> ($stable(staged) && $stable(active) && $stable(en) && $stable(glob)));

endmodule

// File: rtl/led_pwm_counter.sv
module led_pwm_counter
    import led_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output duty_t       cnt_o,
    output logic        wrap_o
);

    duty_t cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign cnt_o  = cnt;
    assign wrap_o = (cnt == '1);

    // R7: the counter rolls over to zero after its top value
    assert_cnt_rollover_R7: assert property (@(posedge clk) disable iff (rst)
        (wrap_o) |=> (cnt_o == '0));

endmodule

// File: rtl/led_pwm_channel.sv
module led_pwm_channel
    import led_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  wrap,
    input  duty_t cnt,
    input  duty_t active,
    input  logic  en,
    input  logic  live,
    output logic  pwm
);

    duty_t cmp;

    always_ff @(posedge clk) begin
        if (rst || clear) cmp <= '0;
        else if (wrap)    cmp <= active;
    end

    assign pwm = en && live && (cnt < cmp);

    // R8: compare value moves only at counter wrap (or clear)
    assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !clear) |=> $stable(cmp));

    // R7: a zero compare value never drives high
    assert_zero_dark_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |-> !pwm);

    // R6: clear empties the compare register
    assert_clear_cmp_R6: assert property (@(posedge clk) disable iff (rst)
        (clear) |=> (cmp == '0));

endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
    import led_pwm_pkg::*;
#(
    parameter int NCH = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NCH-1:0]    pwm_o
);

    logic [NCH-1:0][DUTY_W-1:0] active;
    logic [NCH-1:0]             en;
    logic                       live;
    logic                       clear;
    duty_t                      cnt;
    logic                       wrap;

    led_pwm_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .active_o (active),
        .en_o     (en),
        .live_o   (live),
        .clear_o  (clear)
    );

    led_pwm_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        led_pwm_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .clear  (clear),
            .wrap   (wrap),
            .cnt    (cnt),
            .active (active[i]),
            .en     (en[i]),
            .live   (live),
            .pwm    (pwm_o[i])
        );
    end

    // R4/R5: a halted block drives nothing
    assert_halt_dark_R4: assert property (@(posedge clk) disable iff (rst)
        (!live) |-> (pwm_o == '0));

    // R3: disabled channels stay low
    assert_en_gate_R3: assert property (@(posedge clk) disable iff (rst)
        ((pwm_o & ~en) == '0));

    // R10: outputs low in the cycle after reset
    assert_reset_dark_R10: assert property (@(posedge clk)
        ($past(rst)) |-> (pwm_o == '0));

endmodule

// File: tb/sim_led_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_led_pwm_ctrl;

    localparam int NCH = 36;
    localparam int NV  = 8;
    // {channel, brightness}
    localparam logic [15:0] VEC [NV] = '{
        16'h01FF, 16'h0200, 16'h0301, 16'h1180,
        16'h244D, 16'h14FE, 16'h0903, 16'h1EC8
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int fails  = 0;
    int ph     = 0;
    int hi [NCH];
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    // Bench model of the counter phase (R7): 0 after reset, +1 per clock
    always @(posedge clk) begin
        if (rst) ph <= 0;
        else     ph <= (ph + 1) % 256;
    end

    led_pwm_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ph(input int v);
        @(negedge clk);
        while (ph != v) @(negedge clk);
    endtask

    task automatic settle();
        wait_ph(255);
        wait_ph(5);
    endtask

    task automatic measure();
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) if (pwm_o[c]) hi[c]++;
        end
    endtask

    function automatic int vec_duty(input int ch);
        int d = 0;
        for (int v = 0; v < NV; v++) if (int'(VEC[v][15:8]) == ch) d = int'(VEC[v][7:0]);
        return d;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 outputs low in reset", int'(pwm_o != '0), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 outputs low after reset", int'(pwm_o != '0), 0);

        // enable all, run
        for (int c = 1; c <= NCH; c++) wr(8'h25 + 8'(c), 8'h01);
        wr(8'h00, 8'h01);
        // stage brightness values (R1)
        for (int v = 0; v < NV; v++) wr(VEC[v][15:8], VEC[v][7:0]);
        settle();
        measure();
        for (int c = 0; c < NCH; c++) chk("R1 staged value has no effect before commit", hi[c], 0);

        wr(8'h25, 8'hA5); // R2 commit, data ignored
        settle();
        measure();
        for (int v = 0; v < NV; v++)
            chk("R2/R7 high count equals brightness", hi[int'(VEC[v][15:8]) - 1], int'(VEC[v][7:0]));
        for (int c = 1; c <= NCH; c++)
            if (vec_duty(c) == 0) chk("R1 untouched channel dark", hi[c-1], 0);

        // R3 enable gating
        wr(8'h25 + 8'd17, 8'h00);
        measure();
        chk("R3 disabled channel 17 dark", hi[16], 0);
        chk("R3 other channel unaffected", hi[0], 255);
        wr(8'h25 + 8'd17, 8'h01);
        measure();
        chk("R3 re-enabled channel 17", hi[16], 128);

        // R4 shutdown
        wr(8'h00, 8'h00);
        measure();
        chk("R4 shutdown channel 1", hi[0], 0);
        chk("R4 shutdown channel 36", hi[35], 0);
        wr(8'h00, 8'h01);
        measure();
        chk("R4 run restored channel 1", hi[0], 255);

        // R5 global mask
        wr(8'h4a, 8'h01);
        measure();
        chk("R5 mask channel 30", hi[29], 0);
        wr(8'h4a, 8'h00);
        measure();
        chk("R5 unmask restores channel 36", hi[35], 77);
        chk("R5 unmask restores channel 30", hi[29], 200);

        // R9 unmapped writes
        wr(8'h4b, 8'h00);
        wr(8'hFF, 8'h00);
        wr(8'h50, 8'hFF);
        wr(8'h4e, 8'h00);
        wr(8'h25, 8'h00);
        settle();
        measure();
        chk("R9 channel 1 unchanged", hi[0], 255);
        chk("R9 channel 20 unchanged", hi[19], 254);
        chk("R9 channel 2 unchanged", hi[1], 0);

        // R8 mid-period commit: channel 30 at 200, stage 50
        wr(8'h1E, 8'd50);
        wait_ph(99);
        wr(8'h25, 8'h00);
        wait_ph(150);
        chk("R8 old compare kept until wrap", int'(pwm_o[29]), 1);
        wait_ph(20);
        chk("R8 new compare after wrap, low phase", int'(pwm_o[29]), 1);
        wait_ph(150);
        chk("R8 new compare after wrap, high phase", int'(pwm_o[29]), 0);

        // R6 soft clear
        wait_ph(40);
        wr(8'h4f, 8'h3C);
        chk("R6 outputs low right after clear", int'(pwm_o != '0), 0);
        wr(8'h00, 8'h01);
        wr(8'h26, 8'h01);
        wr(8'h25, 8'h00);
        settle();
        measure();
        chk("R6 brightness cleared", hi[0], 0);
        wr(8'h01, 8'd9);
        wr(8'h25, 8'h00);
        settle();
        measure();
        chk("R6 block usable after clear", hi[0], 9);
        chk("R6 enables cleared", hi[1], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule